// File: doc/BRIEF.md
# Serial Port FIFO Control and Internal Loopback

This block holds the control word of an asynchronous serial port and turns it into the signals that its FIFOs and pins need. A 6-bit control register selects the transmit-request threshold. It also enables hardware flow control, holds each FIFO empty on command, and turns on an internal loopback path. The FIFOs report their occupancy to the block. From those counts the block raises a transmit-data-empty request whenever the transmit FIFO has fallen to the selected number of bytes or below.

The block sits between the bit-level transmitter and receiver and the device pins. When flow control is enabled, the receive occupancy drives the outgoing ready-to-send line and the incoming clear-to-send line gates the transmitter. When flow control is disabled, both handshake lines are forced to their active level. In loopback, serial data and the handshake are turned back inside the block, and the outward pins rest in their idle state.

Top module: `sfc_ctrl`

## Requirements
- R1: While either `por_n` or `mrst_n` is low, every control bit is 0 and `reg_rdata` reads 0.
- R2: A cycle with `reg_wr` high loads `reg_wdata` into the control word, visible on `reg_rdata` from the next cycle. Without a write the word holds. Field positions: [5:4] trigger code, [3] flow-control enable, [2] transmit flush, [1] receive flush, [0] loopback.
- R3: `tx_empty_req` is 1 exactly when `tx_level` is at most the threshold of the current trigger code: code 0 gives TX_DEPTH/2 (32), code 1 gives TX_DEPTH/4 (16), code 2 gives 2, code 3 gives 0.
- R4: After a write of a new trigger code, `tx_empty_req` follows the new threshold from the next cycle on. In the write cycle itself it follows the old code.
- R5: `tx_flush` equals control bit 2 for as long as that bit is set.
- R6: `rx_flush` equals control bit 1, independently of bit 2.
- R7: With flow control disabled, `core_cts_n` is 0 whatever `pin_cts_n` is, and `pin_rts_n` is 0 outside loopback.
- R8: With flow control enabled and loopback off, `pin_rts_n` is 1 exactly when `rx_level >= rts_limit`, and `core_cts_n` follows `pin_cts_n`.
- R9: While `sync_mode` is 1, the enable bit has no effect on the handshake, which behaves as in R7. The bit still reads back as written.
- R10: With loopback on, `core_rxd` equals `core_txd`, `pin_txd` is 1 and `pin_rts_n` is 1. If flow control is enabled, `core_cts_n` equals the internal ready-to-send level of R8 and `pin_cts_n` is ignored.
- R11: With loopback off, `pin_txd` equals `core_txd` and `core_rxd` equals `pin_rxd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mrst_n | input | 1 | Manual reset, active low, asynchronous |
| reg_wr | input | 1 | Control-word write strobe |
| reg_wdata | input | 6 | Control-word write data |
| reg_rdata | output | 6 | Current control word |
| sync_mode | input | 1 | Port is in clocked synchronous mode |
| tx_level | input | 7 | Transmit FIFO occupancy in bytes |
| rx_level | input | 7 | Receive FIFO occupancy in bytes |
| rts_limit | input | 7 | Receive occupancy at which ready-to-send is withdrawn |
| tx_flush | output | 1 | Hold transmit FIFO empty |
| rx_flush | output | 1 | Hold receive FIFO empty |
| tx_empty_req | output | 1 | Transmit-data-empty request |
| core_txd | input | 1 | Serial data from the transmitter |
| core_rxd | output | 1 | Serial data to the receiver |
| core_cts_n | output | 1 | Clear-to-send seen by the transmitter, active low |
| pin_txd | output | 1 | Transmit data pin |
| pin_rxd | input | 1 | Receive data pin |
| pin_rts_n | output | 1 | Ready-to-send pin, active low |
| pin_cts_n | input | 1 | Clear-to-send pin, active low |

## Verification
A write that changes the trigger code can land in the same cycle as a change of transmit occupancy across one of the thresholds. In that cycle the request must still follow the old code, and from the next cycle it must follow the new one. The bench provokes this with directed writes that move `tx_level` in the same cycle, and with random writes mixed into random occupancy. A behavioural model that updates its copy of the control word only at the clock edge judges every cycle. Loopback and flow control switching together in one write are provoked in the same way.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

   localparam int unsigned CTRL_W = 6;

   typedef struct packed {
      logic [1:0] trig;
      logic       mce;
      logic       tx_clr;
      logic       rx_clr;
      logic       loop;
   } sfc_ctrl_t;

   // remaining-byte threshold for a trigger code
   function automatic int unsigned trig_threshold(input logic [1:0] code,
                                                  input int unsigned depth);
      case (code)
         2'd0:    return depth / 2;
         2'd1:    return depth / 4;
         2'd2:    return 2;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/sfc_ctrl_reg.sv
module sfc_ctrl_reg
   import sfc_pkg::*;
(
   input  logic              clk,
   input  logic              por_n,
   input  logic              mrst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wdata,
   output sfc_ctrl_t         ctrl
);

   always_ff @(posedge clk or negedge por_n or negedge mrst_n) begin
      if (!por_n || !mrst_n) begin
         ctrl <= '0;
      end else if (wr_en) begin
         ctrl <= sfc_ctrl_t'(wdata);
      end
   end

endmodule

// File: rtl/sfc_tx_trigger.sv
module sfc_tx_trigger
   import sfc_pkg::*;
#(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
   input  logic [LW-1:0] level,
   input  logic [1:0]    code,
   output logic          flag
);

   localparam int unsigned NCODE = 4;

   logic [NCODE-1:0] hit;

   for (genvar g = 0; g < NCODE; g++) begin : g_cmp
      localparam int unsigned THR = trig_threshold(2'(g), DEPTH);
      assign hit[g] = (level <= LW'(THR));
   end

   assign flag = hit[code];

endmodule

// File: rtl/sfc_loop_route.sv
module sfc_loop_route (
   input  logic loop,
   input  logic core_txd,
   input  logic pin_rxd,
   input  logic rts_int_n,
   input  logic pin_cts_n,
   output logic pin_txd,
   output logic core_rxd,
   output logic pin_rts_n,
   output logic cts_src_n
);

   always_comb begin
      if (loop) begin
         pin_txd   = 1'b1;       // mark idle
         pin_rts_n = 1'b1;       // inactive
         core_rxd  = core_txd;
         cts_src_n = rts_int_n;
      end else begin
         pin_txd   = core_txd;
         pin_rts_n = rts_int_n;
         core_rxd  = pin_rxd;
         cts_src_n = pin_cts_n;
      end
   end

endmodule

// File: rtl/sfc_modem_gate.sv
module sfc_modem_gate #(
   parameter int unsigned LW = 7
) (
   input  logic          mce,
   input  logic          sync_mode,
   input  logic [LW-1:0] rx_level,
   input  logic [LW-1:0] rts_limit,
   input  logic          cts_src_n,
   output logic          rts_int_n,
   output logic          core_cts_n
);

   logic mce_eff;

   assign mce_eff    = mce & ~sync_mode;
   assign rts_int_n  = mce_eff ? (rx_level >= rts_limit) : 1'b0;
   assign core_cts_n = mce_eff ? cts_src_n : 1'b0;

endmodule

// File: rtl/sfc_ctrl.sv
module sfc_ctrl
   import sfc_pkg::*;
#(
   parameter int unsigned TX_DEPTH  = 64,
   parameter int unsigned RX_DEPTH  = 64,
   localparam int unsigned TXL_W    = $clog2(TX_DEPTH + 1),
   localparam int unsigned RXL_W    = $clog2(RX_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              mrst_n,
   input  logic              reg_wr,
   input  logic [CTRL_W-1:0] reg_wdata,
   output logic [CTRL_W-1:0] reg_rdata,
   input  logic              sync_mode,
   input  logic [TXL_W-1:0]  tx_level,
   input  logic [RXL_W-1:0]  rx_level,
   input  logic [RXL_W-1:0]  rts_limit,
   output logic              tx_flush,
   output logic              rx_flush,
   output logic              tx_empty_req,
   input  logic              core_txd,
   output logic              core_rxd,
   output logic              core_cts_n,
   output logic              pin_txd,
   input  logic              pin_rxd,
   output logic              pin_rts_n,
   input  logic              pin_cts_n
);

   if (TX_DEPTH < 8) begin : g_bad_tx
      $error("sfc_ctrl: TX_DEPTH must be at least 8");
   end
   if (RX_DEPTH < 2) begin : g_bad_rx
      $error("sfc_ctrl: RX_DEPTH must be at least 2");
   end

   sfc_ctrl_t ctrl;
   logic      rts_int_n;
   logic      cts_src_n;

   sfc_ctrl_reg i_reg (
      .clk    (clk),
      .por_n  (por_n),
      .mrst_n (mrst_n),
      .wr_en  (reg_wr),
      .wdata  (reg_wdata),
      .ctrl   (ctrl)
   );

   assign reg_rdata = CTRL_W'(ctrl);
   assign tx_flush  = ctrl.tx_clr;
   assign rx_flush  = ctrl.rx_clr;

   sfc_tx_trigger #(.DEPTH(TX_DEPTH)) i_trig (
      .level (tx_level),
      .code  (ctrl.trig),
      .flag  (tx_empty_req)
   );

   sfc_modem_gate #(.LW(RXL_W)) i_modem (
      .mce        (ctrl.mce),
      .sync_mode  (sync_mode),
      .rx_level   (rx_level),
      .rts_limit  (rts_limit),
      .cts_src_n  (cts_src_n),
      .rts_int_n  (rts_int_n),
      .core_cts_n (core_cts_n)
   );

   sfc_loop_route i_loop (
      .loop      (ctrl.loop),
      .core_txd  (core_txd),
      .pin_rxd   (pin_rxd),
      .rts_int_n (rts_int_n),
      .pin_cts_n (pin_cts_n),
      .pin_txd   (pin_txd),
      .core_rxd  (core_rxd),
      .pin_rts_n (pin_rts_n),
      .cts_src_n (cts_src_n)
   );

endmodule

// File: rtl/sfc_ctrl_chk.sv
module sfc_ctrl_chk #(
   parameter int unsigned TX_DEPTH = 64,
   parameter int unsigned RX_DEPTH = 64,
   localparam int unsigned TXL_W   = $clog2(TX_DEPTH + 1),
   localparam int unsigned RXL_W   = $clog2(RX_DEPTH + 1)
) (
   input logic             clk,
   input logic             por_n,
   input logic             mrst_n,
   input logic             reg_wr,
   input logic [5:0]       reg_wdata,
   input logic [5:0]       reg_rdata,
   input logic             sync_mode,
   input logic [TXL_W-1:0] tx_level,
   input logic [RXL_W-1:0] rx_level,
   input logic             tx_flush,
   input logic             rx_flush,
   input logic             tx_empty_req,
   input logic             core_txd,
   input logic             core_rxd,
   input logic             core_cts_n,
   input logic             pin_txd,
   input logic             pin_rts_n
);

   logic in_rst;
   assign in_rst = !por_n || !mrst_n;

   AST_RST_CLEARS: assert property (@(posedge clk) in_rst |-> reg_rdata == 6'd0); // R1
   AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (in_rst)
      reg_wr |=> reg_rdata == $past(reg_wdata)); // R2
   AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (in_rst)
      !reg_wr |=> $stable(reg_rdata)); // R2
   AST_TRIG_ZERO_LEFT: assert property (@(posedge clk) disable iff (in_rst)
      reg_rdata[5:4] == 2'b11 |-> tx_empty_req == (tx_level == '0)); // R3
   AST_TRIG_HALF_QUIET: assert property (@(posedge clk) disable iff (in_rst)
      (reg_rdata[5:4] == 2'b00 && tx_level > TXL_W'(TX_DEPTH / 2)) |-> !tx_empty_req); // R3
   AST_TX_FLUSH_BIT: assert property (@(posedge clk) disable iff (in_rst)
      tx_flush == reg_rdata[2]); // R5
   AST_RX_FLUSH_BIT: assert property (@(posedge clk) disable iff (in_rst)
      rx_flush == reg_rdata[1]); // R6
   AST_MODEM_FORCED: assert property (@(posedge clk) disable iff (in_rst)
      (!reg_rdata[3] || sync_mode) |-> !core_cts_n); // R7
   AST_SYNC_IGNORES: assert property (@(posedge clk) disable iff (in_rst)
      (sync_mode && !reg_rdata[0]) |-> !pin_rts_n); // R9
   AST_LOOP_ISOLATE: assert property (@(posedge clk) disable iff (in_rst)
      reg_rdata[0] |-> (core_rxd == core_txd && pin_txd && pin_rts_n)); // R10
   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (in_rst)
      !reg_rdata[0] |-> pin_txd == core_txd); // R11

endmodule

bind sfc_ctrl sfc_ctrl_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) i_chk (
   .clk          (clk),
   .por_n        (por_n),
   .mrst_n       (mrst_n),
   .reg_wr       (reg_wr),
   .reg_wdata    (reg_wdata),
   .reg_rdata    (reg_rdata),
   .sync_mode    (sync_mode),
   .tx_level     (tx_level),
   .rx_level     (rx_level),
   .tx_flush     (tx_flush),
   .rx_flush     (rx_flush),
   .tx_empty_req (tx_empty_req),
   .core_txd     (core_txd),
   .core_rxd     (core_rxd),
   .core_cts_n   (core_cts_n),
   .pin_txd      (pin_txd),
   .pin_rts_n    (pin_rts_n)
);

// File: tb/test_sfc_ctrl.sv
`timescale 1ns/1ps
module test_sfc_ctrl;

   logic       clk = 1'b0;
   logic       por_n = 1'b0, mrst_n = 1'b1;
   logic       reg_wr = 1'b0;
   logic [5:0] reg_wdata = '0;
   logic [5:0] reg_rdata;
   logic       sync_mode = 1'b0;
   logic [6:0] tx_level = '0, rx_level = '0, rts_limit = 7'd62;
   logic       tx_flush, rx_flush, tx_empty_req;
   logic       core_txd = 1'b1, core_rxd, core_cts_n;
   logic       pin_txd, pin_rxd = 1'b1, pin_rts_n, pin_cts_n = 1'b1;

   int total = 0, fails = 0;
   bit done = 0;

   // model state
   int m_word = 0;
   int m_prev_trig = 0;
   bit trig_changed = 0;

   always #2.5 clk = ~clk;

   sfc_ctrl i_sfc_ctrl (.*);

   // behavioural model of the control word
   always @(posedge clk or negedge por_n or negedge mrst_n) begin
      if (!por_n || !mrst_n) begin
         trig_changed = (m_word / 16) != 0;
         m_word = 0;
      end else begin
         m_prev_trig = m_word / 16;
         if (reg_wr) m_word = int'(reg_wdata);
         trig_changed = (m_word / 16) != m_prev_trig;
      end
   end

   function automatic int thr(int code);
      if (code == 0) return 32;
      if (code == 1) return 16;
      if (code == 2) return 2;
      return 0;
   endfunction

   task automatic cmp(input int act, input int exp, input string tag, input string what);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         if (!por_n || !mrst_n) begin
            cmp(reg_rdata, 0, "R1", "reg_rdata in reset");
         end else begin
            automatic int  trig = m_word / 16;
            automatic bit  mce  = (m_word / 8) % 2;
            automatic bit  tclr = (m_word / 4) % 2;
            automatic bit  rclr = (m_word / 2) % 2;
            automatic bit  lp   = m_word % 2;
            automatic bit  eff  = mce && !sync_mode;
            automatic bit  rts  = eff ? (int'(rx_level) >= int'(rts_limit)) : 1'b0;
            automatic bit  e_req = int'(tx_level) <= thr(trig);
            automatic string mtag = lp ? "R10" : (sync_mode && mce) ? "R9" : mce ? "R8" : "R7";
            cmp(reg_rdata, m_word, "R2", "reg_rdata");
            cmp(tx_empty_req, e_req, trig_changed ? "R4" : "R3", "tx_empty_req");
            cmp(tx_flush, tclr, "R5", "tx_flush");
            cmp(rx_flush, rclr, "R6", "rx_flush");
            cmp(pin_rts_n, lp ? 1'b1 : rts, mtag, "pin_rts_n");
            cmp(core_cts_n, eff ? (lp ? rts : pin_cts_n) : 1'b0, mtag, "core_cts_n");
            cmp(pin_txd, lp ? 1'b1 : core_txd, lp ? "R10" : "R11", "pin_txd");
            cmp(core_rxd, lp ? core_txd : pin_rxd, lp ? "R10" : "R11", "core_rxd");
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [5:0] v);
      reg_wr = 1'b1; reg_wdata = v;
      step();
      reg_wr = 1'b0;
   endtask

   initial begin
      repeat (3) step();
      por_n = 1'b1;
      step();
      // R3: sweep every trigger code across the full occupancy range
      for (int c = 0; c < 4; c++) begin
         wr(6'(c * 16));
         for (int l = 0; l <= 64; l++) begin
            tx_level = 7'(l);
            step();
         end
      end
      // R4: trigger write in the same cycle as an occupancy crossing
      tx_level = 7'd3;
      wr(6'b100000);
      tx_level = 7'd2;
      wr(6'b110000);
      tx_level = 7'd20;
      wr(6'b000000);
      tx_level = 7'd33;
      wr(6'b010000);
      step();
      // R5 R6: flushes alone and together
      wr(6'b000100); step();
      wr(6'b000010); step();
      wr(6'b000110); step();
      wr(6'b000000); step();
      // R7 then R8: flow control off and on
      for (int l = 58; l <= 64; l++) begin
         rx_level = 7'(l); pin_cts_n = l[0];
         step();
      end
      wr(6'b001000);
      for (int l = 58; l <= 64; l++) begin
         rx_level = 7'(l); pin_cts_n = l[0];
         step();
      end
      // R9: synchronous mode overrides enable
      sync_mode = 1'b1;
      for (int l = 60; l <= 64; l++) begin
         rx_level = 7'(l); pin_cts_n = ~l[0];
         step();
      end
      sync_mode = 1'b0;
      // R10: loopback with and without flow control, flipped in one write
      wr(6'b001001);
      for (int i = 0; i < 8; i++) begin
         core_txd = i[0]; pin_rxd = ~i[0]; pin_cts_n = i[1];
         rx_level = (i < 4) ? 7'd10 : 7'd63;
         step();
      end
      wr(6'b000001);
      for (int i = 0; i < 4; i++) begin
         core_txd = i[0]; pin_rxd = i[1];
         step();
      end
      // R11: pass-through
      wr(6'b000000);
      for (int i = 0; i < 4; i++) begin
         core_txd = i[0]; pin_rxd = i[1];
         step();
      end
      // mixed random traffic
      for (int i = 0; i < 600; i++) begin
         reg_wr    = ($urandom_range(0, 5) == 0);
         reg_wdata = 6'($urandom);
         sync_mode = ($urandom_range(0, 7) == 0);
         tx_level  = 7'($urandom_range(0, 64));
         rx_level  = 7'($urandom_range(0, 64));
         rts_limit = 7'($urandom_range(40, 64));
         core_txd  = 1'($urandom); pin_rxd = 1'($urandom); pin_cts_n = 1'($urandom);
         step();
      end
      reg_wr = 1'b0;
      // R1: manual reset clears a nonzero word
      wr(6'b111111);
      step();
      mrst_n = 1'b0;
      step(); step();
      mrst_n = 1'b1;
      step();
      cmp(reg_rdata, 0, "R1", "reg_rdata after manual reset");
      step();
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1;
         total++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule